// File: doc/BRIEF.md
# Stop-Clock and Management-Interrupt Sequencer

This block is the power and system-management front end of a simple processor bus model. A level-sensitive stop-clock request makes it issue one acknowledge bus cycle on a valid/ready port. The cycle carries a fixed address and a cycle-type code. Once the cycle is accepted, the block parks in a clock-stopped state. It stays there until the request is withdrawn. On the way out it samples the NMI and INTR lines one clock after the release and reports which of them were still active.

The block also takes an asynchronous, active-low management-interrupt line. The line passes through a synchronizer and a pulse-width qualifier that requires a minimum high time followed by a minimum low time. A qualified request sits in a one-entry slot. The sequencer takes it and raises the management-active output. It leaves that mode when the core strobes resume, and the strobe carries the handler's relocated base. A base that is not aligned to 32 KiB sends the block into a terminal shutdown state, and it announces that state with its own bus cycle.

The bus cycle port follows valid/ready rules. `cyc_valid` rises with address and type already valid. All three hold steady until a cycle in which `cyc_ready` is also high, and that cycle is the transfer. `cyc_ready` may stay low for any number of cycles. Nothing else in the block waits on the port.

Top module: `pm_stop_smi_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every output is low.
- R2: A stop request seen while idle raises `cyc_valid` one cycle later, with address 0000_0010h and type 2'b01. Valid, address and type stay stable until a cycle with `cyc_ready` high.
- R3: After the acknowledge transfer, `clk_stopped` is high and no further bus cycle is issued for as long as `stop_req` stays high.
- R4: The first clock edge that sees `stop_req` low ends the stopped state. NMI and INTR are sampled at the next edge, and each line that is high there gives a one-cycle pulse on its wake output.
- R5: A low level on `smi_n` is accepted only after the synchronized line was high for at least 2 clocks and then low for at least 2 clocks. A shorter low or a shorter preceding high has no effect.
- R6: An accepted request raises `mgmt_active`. A resume strobe with the low 15 bits of `rsm_base` zero clears it at the next edge.
- R7: While `mgmt_active` is high, accepted requests collapse into a single pending one. It is taken right after resume, so exactly one re-entry follows.
- R8: A resume strobe with any of the low 15 bits of `rsm_base` set issues a bus cycle with address 0 and type 2'b10. After that transfer `shut_down` stays high until reset, and stop requests are ignored.
- R9: When a pending management request and a stop request are both present while idle, management mode is entered first. The acknowledge cycle is issued only after that mode is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Stop-clock request level |
| smi_n | input | 1 | Asynchronous management interrupt, active low |
| nmi_in | input | 1 | Non-maskable interrupt level |
| intr_in | input | 1 | Maskable interrupt level |
| rsm_stb | input | 1 | Resume strobe from the core, one cycle |
| rsm_base | input | 32 | Relocated handler base presented with the resume strobe |
| cyc_valid | output | 1 | Bus cycle request valid |
| cyc_ready | input | 1 | Bus accepts the cycle |
| cyc_addr | output | 32 | Bus cycle address |
| cyc_type | output | 2 | Cycle type: 01 acknowledge, 10 shutdown |
| mgmt_active | output | 1 | Management mode active |
| clk_stopped | output | 1 | Parked in the clock-stopped state |
| shut_down | output | 1 | Terminal shutdown state reached |
| nmi_wake | output | 1 | NMI seen on stop exit, one-cycle pulse |
| intr_wake | output | 1 | INTR seen on stop exit, one-cycle pulse |

## Verification
The hardest situation to reach from the ports is the one where a pending management request and a stop request meet in the same idle cycle. A race on the raw input lines cannot land this on an exact cycle, because the synchronizer and the qualifier add latency. The bench reaches it another way. It latches a nested request while the block is in management mode and raises `stop_req` in that same window, so both are waiting when resume returns the sequencer to idle. The qualifier's high-width rule is reached by leaving the line low after an accepted request and then giving it only a one-cycle high before another long low.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GNT_REQ,
    ST_GNT_HOLD,
    ST_GNT_EXIT,
    ST_MGMT,
    ST_SD_REQ,
    ST_SD_HALT
  } seq_state_t;

  localparam logic [1:0] CYC_STOP_GRANT = 2'b01;
  localparam logic [1:0] CYC_SHUTDOWN   = 2'b10;

endpackage

// File: rtl/smi_qual.sv
module smi_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HI      = 2,
  parameter int MIN_LO      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic accept
);
  localparam int HW = $clog2(MIN_HI + 1);
  localparam int LW = $clog2(MIN_LO + 1);

  logic [SYNC_STAGES-1:0] sr;
  logic                   sync_n;
  logic [HW-1:0]          hi_cnt;
  logic [LW-1:0]          lo_cnt;
  logic                   armed;

  // synchronizer chain, resets to the inactive (high) level
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= line_n;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[SYNC_STAGES-2:0], line_n};
    end
  endgenerate

  assign sync_n = sr[SYNC_STAGES-1];
  assign accept = armed && !sync_n && (lo_cnt == LW'(MIN_LO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      // high-width counter: any low sample restarts it
      if (sync_n) begin
        if (hi_cnt != HW'(MIN_HI)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      // low-width counter: runs only once armed, any high sample restarts it
      if (accept || sync_n || !armed) lo_cnt <= '0;
      else if (lo_cnt != LW'(MIN_LO)) lo_cnt <= lo_cnt + 1'b1;
      // arming needs MIN_HI consecutive high samples
      if (accept)                                   armed <= 1'b0;
      else if (sync_n && hi_cnt >= HW'(MIN_HI - 1)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/req_slot.sv
module req_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic take,
  output logic pend
);
  // one entry: further sets while full merge into the same request
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !take) || set;
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pmseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] GRANT_ADDR = 32'h0000_0010,
  parameter int          ALIGN_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic          pend,
  input  logic          nmi_in,
  input  logic          intr_in,
  input  logic          rsm_stb,
  input  logic [AW-1:0] rsm_base,
  input  logic          cyc_ready,
  output logic          take,
  output logic          cyc_valid,
  output logic [AW-1:0] cyc_addr,
  output logic [1:0]    cyc_type,
  output logic          mgmt_active,
  output logic          clk_stopped,
  output logic          shut_down,
  output logic          nmi_wake,
  output logic          intr_wake
);
  seq_state_t state, state_nx;
  logic       base_ok;

  assign base_ok = (rsm_base[ALIGN_BITS-1:0] == '0);
  assign take    = (state == ST_IDLE) && pend;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (pend) state_nx = ST_MGMT;
                   else if (stop_req) state_nx = ST_GNT_REQ;
      ST_GNT_REQ:  if (cyc_ready) state_nx = ST_GNT_HOLD;
      ST_GNT_HOLD: if (!stop_req) state_nx = ST_GNT_EXIT;
      ST_GNT_EXIT: state_nx = ST_IDLE;
      ST_MGMT:     if (rsm_stb) state_nx = base_ok ? ST_IDLE : ST_SD_REQ;
      ST_SD_REQ:   if (cyc_ready) state_nx = ST_SD_HALT;
      ST_SD_HALT:  state_nx = ST_SD_HALT;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nmi_wake  <= 1'b0;
      intr_wake <= 1'b0;
    end else begin
      state     <= state_nx;
      nmi_wake  <= (state == ST_GNT_EXIT) && nmi_in;
      intr_wake <= (state == ST_GNT_EXIT) && intr_in;
    end
  end

  assign cyc_valid   = (state == ST_GNT_REQ) || (state == ST_SD_REQ);
  assign cyc_addr    = (state == ST_GNT_REQ) ? GRANT_ADDR[AW-1:0] : '0;
  assign cyc_type    = (state == ST_GNT_REQ) ? CYC_STOP_GRANT :
                       (state == ST_SD_REQ)  ? CYC_SHUTDOWN   : 2'b00;
  assign mgmt_active = (state == ST_MGMT);
  assign clk_stopped = (state == ST_GNT_HOLD);
  assign shut_down   = (state == ST_SD_HALT);
endmodule

// File: rtl/pm_stop_smi_seq.sv
module pm_stop_smi_seq #(
  parameter int          AW          = 32,
  parameter logic [31:0] GRANT_ADDR  = 32'h0000_0010,
  parameter int          ALIGN_BITS  = 15,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_HI      = 2,
  parameter int          MIN_LO      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic          smi_n,
  input  logic          nmi_in,
  input  logic          intr_in,
  input  logic          rsm_stb,
  input  logic [AW-1:0] rsm_base,
  output logic          cyc_valid,
  input  logic          cyc_ready,
  output logic [AW-1:0] cyc_addr,
  output logic [1:0]    cyc_type,
  output logic          mgmt_active,
  output logic          clk_stopped,
  output logic          shut_down,
  output logic          nmi_wake,
  output logic          intr_wake
);
  logic accept, pend, take;

  smi_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_qual (
    .clk(clk), .rst_n(rst_n), .line_n(smi_n), .accept(accept)
  );

  req_slot u_slot (
    .clk(clk), .rst_n(rst_n), .set(accept), .take(take), .pend(pend)
  );

  pm_fsm #(.AW(AW), .GRANT_ADDR(GRANT_ADDR), .ALIGN_BITS(ALIGN_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .pend(pend),
    .nmi_in(nmi_in), .intr_in(intr_in), .rsm_stb(rsm_stb), .rsm_base(rsm_base),
    .cyc_ready(cyc_ready), .take(take), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_type(cyc_type), .mgmt_active(mgmt_active),
    .clk_stopped(clk_stopped), .shut_down(shut_down),
    .nmi_wake(nmi_wake), .intr_wake(intr_wake)
  );
endmodule

// File: rtl/pm_stop_smi_seq_chk.sv
module pm_stop_smi_seq_chk #(
  parameter int          AW         = 32,
  parameter logic [31:0] GRANT_ADDR = 32'h0000_0010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_req,
  input logic          rsm_stb,
  input logic          cyc_valid,
  input logic          cyc_ready,
  input logic [AW-1:0] cyc_addr,
  input logic [1:0]    cyc_type,
  input logic          mgmt_active,
  input logic          clk_stopped,
  input logic          shut_down
);
  a_r2_grant_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 2'b01) |-> cyc_addr == GRANT_ADDR[AW-1:0]);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_type)));

  a_r3_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stopped && stop_req) |=> (clk_stopped && !cyc_valid));

  a_r6_resume_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_active && rsm_stb) |=> !mgmt_active);

  a_r8_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shut_down |=> (shut_down && !cyc_valid && !mgmt_active));

  a_r9_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mgmt_active && clk_stopped));
endmodule

bind pm_stop_smi_seq pm_stop_smi_seq_chk #(.AW(AW), .GRANT_ADDR(GRANT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rsm_stb(rsm_stb),
  .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
  .cyc_type(cyc_type), .mgmt_active(mgmt_active), .clk_stopped(clk_stopped),
  .shut_down(shut_down)
);

// File: tb/pm_stop_smi_seq_test.sv
`timescale 1ns/100ps
module pm_stop_smi_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_req = 1'b0, smi_n = 1'b1, nmi_in = 1'b0, intr_in = 1'b0;
  logic        rsm_stb = 1'b0, cyc_ready = 1'b1;
  logic [31:0] rsm_base = '0;
  logic        cyc_valid, mgmt_active, clk_stopped, shut_down, nmi_wake, intr_wake;
  logic [31:0] cyc_addr;
  logic [1:0]  cyc_type;

  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;
  logic [33:0] exp_q[$];

  always #2 clk = ~clk;

  pm_stop_smi_seq uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .smi_n(smi_n),
    .nmi_in(nmi_in), .intr_in(intr_in), .rsm_stb(rsm_stb), .rsm_base(rsm_base),
    .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
    .cyc_type(cyc_type), .mgmt_active(mgmt_active), .clk_stopped(clk_stopped),
    .shut_down(shut_down), .nmi_wake(nmi_wake), .intr_wake(intr_wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look();
    #1.5;
  endtask

  task automatic push_cycle(logic [31:0] a, logic [1:0] t);
    exp_q.push_back({t, a});
  endtask

  // qualified request: 4 high, 5 low, optionally left low
  task automatic smi_pulse(bit leave_low);
    smi_n = 1'b1; step(4);
    smi_n = 1'b0; step(5);
    if (!leave_low) smi_n = 1'b1;
  endtask

  task automatic resume(logic [31:0] base);
    rsm_stb = 1'b1; rsm_base = base; step(1);
    rsm_stb = 1'b0;
  endtask

  // scoreboard monitor: one transfer per valid && ready cycle
  always begin
    @(negedge clk); #1.5;
    if (rst_n && cyc_valid && cyc_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected bus cycle", {cyc_type, cyc_addr[29:0]}, 32'hx);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check("R2/R8 bus cycle addr", cyc_addr, e[31:0]);
        check("R2/R8 bus cycle type", {30'd0, cyc_type}, {30'd0, e[33:32]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(3); look();
    check("R1 valid in reset", {31'd0, cyc_valid}, 0);
    check("R1 mgmt in reset", {31'd0, mgmt_active}, 0);
    step(1); rst_n = 1'b1; look();
    check("R1 outputs after reset",
          {26'd0, cyc_valid, mgmt_active, clk_stopped, shut_down, nmi_wake, intr_wake}, 0);
    step(5);

    // R2: acknowledge cycle with back-pressure
    cyc_ready = 1'b0; stop_req = 1'b1; push_cycle(32'h10, 2'b01);
    step(1); look();
    check("R2 valid rises", {31'd0, cyc_valid}, 1);
    check("R2 addr", cyc_addr, 32'h10);
    step(3); look();
    check("R2 valid held under back-pressure", {31'd0, cyc_valid}, 1);
    check("R2 type held", {30'd0, cyc_type}, 1);
    step(1); cyc_ready = 1'b1;
    step(1); look();
    check("R3 stopped after transfer", {31'd0, clk_stopped}, 1);
    step(5); look();
    check("R3 still stopped, no repeat", {30'd0, clk_stopped, cyc_valid}, 2);

    // R4: NMI held through exit
    step(1); stop_req = 1'b0; nmi_in = 1'b1;
    step(2); look();
    check("R4 nmi wake pulse", {30'd0, nmi_wake, intr_wake}, 2);
    check("R4 left stopped state", {31'd0, clk_stopped}, 0);
    step(1); nmi_in = 1'b0; look();
    check("R4 nmi wake is one cycle", {31'd0, nmi_wake}, 0);

    // R4: INTR raised only in the sampling cycle
    stop_req = 1'b1; push_cycle(32'h10, 2'b01);
    step(5); stop_req = 1'b0;
    step(1); intr_in = 1'b1;
    step(1); look();
    check("R4 intr wake pulse", {30'd0, nmi_wake, intr_wake}, 1);
    intr_in = 1'b0; step(3);

    // R5: one-cycle low is ignored
    smi_n = 1'b0; step(1); smi_n = 1'b1; step(8); look();
    check("R5 short low ignored", {31'd0, mgmt_active}, 0);

    // R5/R6: qualified entry, line left low
    smi_pulse(1'b1); look();
    check("R6 mgmt entered", {31'd0, mgmt_active}, 1);
    // R5: only one high cycle before a long low: not accepted
    step(1); smi_n = 1'b1; step(1); smi_n = 1'b0; step(6); smi_n = 1'b1;
    step(1); resume(32'h0003_8000); look();
    check("R6 mgmt cleared on aligned resume", {31'd0, mgmt_active}, 0);
    step(6); look();
    check("R5 short high before low ignored", {31'd0, mgmt_active}, 0);

    // R7: two nested requests collapse to one
    smi_pulse(1'b0); look();
    check("R7 entered", {31'd0, mgmt_active}, 1);
    smi_pulse(1'b0); smi_pulse(1'b0);
    step(2); resume(32'h0); look();
    check("R7 exit after resume", {31'd0, mgmt_active}, 0);
    step(1); look();
    check("R7 single re-entry", {31'd0, mgmt_active}, 1);
    step(2); resume(32'h0);
    step(8); look();
    check("R7 no second re-entry", {31'd0, mgmt_active}, 0);

    // R9: pending request and stop request meet in idle
    smi_pulse(1'b0); smi_pulse(1'b0);
    stop_req = 1'b1; push_cycle(32'h10, 2'b01);
    step(2); resume(32'h0);
    step(1); look();
    check("R9 management wins", {30'd0, mgmt_active, cyc_valid}, 2);
    step(2); resume(32'h0);
    step(2); look();
    check("R9 acknowledge after exit", {31'd0, clk_stopped}, 1);
    stop_req = 1'b0; step(4);

    // R8: misaligned base forces shutdown
    smi_pulse(1'b0); push_cycle(32'h0, 2'b10);
    step(1); resume(32'h0000_4000); look();
    check("R8 shutdown cycle valid", {31'd0, cyc_valid}, 1);
    step(2); look();
    check("R8 shut_down high", {30'd0, shut_down, mgmt_active}, 2);
    stop_req = 1'b1; step(6); look();
    check("R8 stop ignored in shutdown", {30'd0, shut_down, cyc_valid}, 2);
    check("R2 all cycles seen", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule